// File: doc/BRIEF.md
# PRBS Packet Test Engine

A built-in self-test engine for a link datapath. Its generator emits bytes in bursts called packets, of a configurable number of bytes, with a configurable number of idle cycles between them. In pseudo-random mode the payload is a PRBS-7 stream that runs on from one packet to the next. In fixed mode a single packet of incrementing bytes goes out on request. A loopback or a link partner returns the bytes to the checker. The checker synchronises itself to the received stream, then counts errored bits, received bytes and received packets.

The three counters run either saturating or wrapping, and the packet and byte counters each keep a sticky overflow flag. Software never reads the live counters. A latch command copies all three into snapshot outputs. A clear command copies them and then zeroes the counters and both overflow flags. Status outputs report lock, a sticky loss-of-sync flag, generator busy, packet done and a pending send request.

Top module: `bist_pkt_engine`

## Requirements
- R1: After a synchronous reset, tx_valid, tx_last, busy, send_pend, pkt_done, locked, sync_loss, pkt_ovf, byte_ovf, wrap_pulse and all three snapshots are zero.
- R2: With prbs_mode=0 and gen_en=1, a send_req pulse sets send_pend and clears pkt_done. It then produces one packet of pkt_len bytes valued 0,1,2,... with tx_last on the final byte and busy high on every byte. After that packet pkt_done is 1 and send_pend has cleared itself.
- R3: With prbs_mode=1 and gen_en=1, packets of pkt_len bytes repeat with exactly gap_len idle cycles between them. Each byte is the next eight bits of the sequence x[n]=x[n-7] XOR x[n-6], oldest bit in bit 7. So a byte is determined by the low seven bits of the byte before it, which are its last seven sequence bits.
- R4: The checker is active only when chk_en=1 and (prbs_mode=1 or gen_en=1). Bytes received while it is inactive change no counter.
- R5: The checker declares locked after 8 consecutive bytes that match its prediction from the preceding received byte. While locked, the number of bits by which each received byte differs from the running prediction is added to the error counter. No errors are counted while the checker is unlocked.
- R6: While locked, 4 consecutive errored bytes drop locked and set sync_loss. sync_loss stays set until a stat_ack pulse.
- R7: A cmd_latch pulse copies the packet, byte and error counters into pkt_snap, byte_snap and err_snap while counting continues. The snapshots change on no other cycle except a clear.
- R8: A cmd_clear pulse copies the counters into the snapshots, clears pkt_ovf and byte_ovf, and restarts the counters from zero. A byte taken in the same cycle counts after the clear and is not in the snapshot.
- R9: With cont_mode=0, the packet and byte counters stop at all ones and the error counter stops at 0xFF.
- R10: With cont_mode=1, every counter wraps modulo its range, and each wrap gives a one-cycle wrap_pulse.
- R11: pkt_ovf sets when a packet is counted while the packet counter is at all ones. byte_ovf sets likewise for the byte counter. The two flags are independent and stay set until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Generator enable |
| prbs_mode | input | 1 | 1: continuous PRBS packets; 0: single fixed packet on request |
| send_req | input | 1 | Pulse requesting one fixed packet |
| chk_en | input | 1 | Checker enable |
| cont_mode | input | 1 | 1: counters wrap; 0: counters saturate |
| pkt_len | input | LEN_W | Packet length in bytes |
| gap_len | input | GAP_W | Idle cycles between packets |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte valid |
| rx_last | input | 1 | Received byte ends a packet |
| cmd_latch | input | 1 | Snapshot counters |
| cmd_clear | input | 1 | Snapshot, then clear counters and overflow flags |
| stat_ack | input | 1 | Clears sync_loss |
| tx_data | output | 8 | Generated byte |
| tx_valid | output | 1 | Generated byte valid |
| tx_last | output | 1 | Generated byte ends a packet |
| busy | output | 1 | Generation in progress |
| send_pend | output | 1 | Fixed-packet request pending |
| pkt_done | output | 1 | Fixed packet fully sent |
| locked | output | 1 | Checker synchronised |
| sync_loss | output | 1 | Sticky loss of synchronisation |
| pkt_ovf | output | 1 | Sticky packet counter overflow |
| byte_ovf | output | 1 | Sticky byte counter overflow |
| err_snap | output | ERR_W | Latched error bit count |
| pkt_snap | output | PKT_W | Latched packet count |
| byte_snap | output | BYTE_W | Latched byte count |
| wrap_pulse | output | 1 | One-cycle pulse on any counter wrap |

## Verification
A clear command can arrive in the same cycle as a received byte that closes a packet, so the snapshot copy and the counter increment compete for one edge. The bench drives the receive side directly: it sends three one-byte packets, then a fourth together with cmd_clear. The snapshot must read three packets and three bytes, and a later latch must read one and one. The error counter is provoked in the same way by latching during traffic that carries injected errors, and the latched error total must match the injected bit count exactly.

// File: rtl/bist_pkt_pkg.sv
package bist_pkt_pkg;

  typedef enum logic [1:0] {G_IDLE, G_DATA, G_GAP} gen_state_t;

  // Eight steps of the x^7 + x^6 + 1 register; bit 0 of the result is the newest bit.
  function automatic logic [7:0] prbs7_byte(input logic [6:0] seed);
    logic [6:0] s;
    logic [7:0] b;
    s = seed;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      b = {b[6:0], s[6] ^ s[5]};
      s = {s[5:0], s[6] ^ s[5]};
    end
    return b;
  endfunction

endpackage

// File: rtl/bist_pkt_gen.sv
module bist_pkt_gen
  import bist_pkt_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gen_en,
  input  logic             prbs_mode,
  input  logic             send_req,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [GAP_W-1:0] gap_len,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  output logic             tx_last,
  output logic             busy,
  output logic             send_pend,
  output logic             pkt_done
);

  gen_state_t       st;
  logic [LEN_W-1:0] bcnt;
  logic [GAP_W-1:0] gcnt;
  logic [6:0]       lfsr;
  logic             cur_prbs;
  logic [7:0]       nxt_prbs;
  logic             end_pkt;
  logic             end_gap;

  assign nxt_prbs = prbs7_byte(lfsr);
  assign end_pkt  = ({1'b0, bcnt} + 1'b1) >= {1'b0, pkt_len};
  assign end_gap  = ({1'b0, gcnt} + 1'b1) >= {1'b0, gap_len};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= G_IDLE;
      bcnt      <= '0;
      gcnt      <= '0;
      lfsr      <= 7'h7F;
      cur_prbs  <= 1'b0;
      tx_data   <= '0;
      tx_valid  <= 1'b0;
      tx_last   <= 1'b0;
      busy      <= 1'b0;
      send_pend <= 1'b0;
      pkt_done  <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      busy     <= (st != G_IDLE);
      case (st)
        G_IDLE: begin
          if (gen_en && (prbs_mode || send_pend)) begin
            st       <= G_DATA;
            bcnt     <= '0;
            cur_prbs <= prbs_mode;
          end
        end
        G_DATA: begin
          tx_valid <= 1'b1;
          if (cur_prbs) begin
            tx_data <= nxt_prbs;
            lfsr    <= nxt_prbs[6:0];
          end else begin
            tx_data <= 8'(bcnt);
          end
          if (end_pkt) begin
            tx_last <= 1'b1;
            bcnt    <= '0;
            gcnt    <= '0;
            if (!cur_prbs) begin
              pkt_done  <= 1'b1;
              send_pend <= 1'b0;
              st        <= G_IDLE;
            end else if (!gen_en) begin
              st <= G_IDLE;
            end else if (gap_len != '0) begin
              st <= G_GAP;
            end
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        G_GAP: begin
          gcnt <= gcnt + 1'b1;
          if (end_gap) st <= gen_en ? G_DATA : G_IDLE;
        end
        default: st <= G_IDLE;
      endcase
      if (send_req) begin
        send_pend <= 1'b1;
        pkt_done  <= 1'b0;
      end
    end
  end

  assert_last_in_pkt_R2: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);
  assert_busy_on_byte_R2: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);
  assert_done_drops_req_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_done) |-> !send_pend);

endmodule

// File: rtl/bist_pkt_cnt.sv
module bist_pkt_cnt #(
  parameter int W     = 8,
  parameter int INC_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cont,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     cnt,
  output logic             over
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W:0] sum;

  assign sum  = {1'b0, cnt} + {{(W+1-INC_W){1'b0}}, inc};
  assign over = sum[W] & ~clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= W'(inc);
    end else if (sum[W] && !cont) begin
      cnt <= MAXV;
    end else begin
      cnt <= sum[W-1:0];
    end
  end

  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!cont && !clr && cnt == MAXV) |=> (cnt == MAXV));
  assert_wrap_leaves_max_R10: assert property (@(posedge clk) disable iff (rst)
    (cont && !clr && cnt == MAXV && inc != '0) |=> (cnt != MAXV));

endmodule

// File: rtl/bist_pkt_chk.sv
module bist_pkt_chk
  import bist_pkt_pkg::*;
#(
  parameter int PKT_W    = 8,
  parameter int BYTE_W   = 10,
  parameter int ERR_W    = 8,
  parameter int LOCK_RUN = 8,
  parameter int LOSS_RUN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic              cont,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic              cmd_latch,
  input  logic              cmd_clear,
  input  logic              stat_ack,
  output logic              locked,
  output logic              sync_loss,
  output logic              pkt_ovf,
  output logic              byte_ovf,
  output logic [ERR_W-1:0]  err_snap,
  output logic [PKT_W-1:0]  pkt_snap,
  output logic [BYTE_W-1:0] byte_snap,
  output logic              wrap_pulse
);

  localparam int RUN_MAX = (LOCK_RUN > LOSS_RUN) ? LOCK_RUN : LOSS_RUN;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic [6:0]        pred;
  logic [RUN_W-1:0]  run;
  logic [7:0]        exp_b;
  logic [7:0]        diff;
  logic [3:0]        nerr;
  logic              bad;
  logic              take;
  logic [3:0]        err_inc;
  logic [PKT_W-1:0]  pkt_cnt;
  logic [BYTE_W-1:0] byte_cnt;
  logic [ERR_W-1:0]  err_cnt;
  logic              pkt_over, byte_over, err_over;

  assign take    = rx_valid && act;
  assign exp_b   = prbs7_byte(pred);
  assign diff    = exp_b ^ rx_data;
  assign nerr    = 4'($countones(diff));
  assign bad     = |diff;
  assign err_inc = (take && locked) ? nerr : 4'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pred      <= '0;
      run       <= '0;
      locked    <= 1'b0;
      sync_loss <= 1'b0;
    end else begin
      if (stat_ack) sync_loss <= 1'b0;
      if (!act) begin
        locked <= 1'b0;
        run    <= '0;
      end else if (rx_valid) begin
        if (!locked) begin
          pred <= rx_data[6:0];
          if (bad) begin
            run <= '0;
          end else if (run == RUN_W'(LOCK_RUN - 1)) begin
            locked <= 1'b1;
            run    <= '0;
          end else begin
            run <= run + 1'b1;
          end
        end else begin
          pred <= exp_b[6:0];
          if (!bad) begin
            run <= '0;
          end else if (run == RUN_W'(LOSS_RUN - 1)) begin
            locked    <= 1'b0;
            run       <= '0;
            sync_loss <= 1'b1;
          end else begin
            run <= run + 1'b1;
          end
        end
      end
    end
  end

  bist_pkt_cnt #(.W(PKT_W), .INC_W(1)) u_pkt_cnt (
    .clk(clk), .rst(rst), .cont(cont), .clr(cmd_clear),
    .inc(take && rx_last), .cnt(pkt_cnt), .over(pkt_over));

  bist_pkt_cnt #(.W(BYTE_W), .INC_W(1)) u_byte_cnt (
    .clk(clk), .rst(rst), .cont(cont), .clr(cmd_clear),
    .inc(take), .cnt(byte_cnt), .over(byte_over));

  bist_pkt_cnt #(.W(ERR_W), .INC_W(4)) u_err_cnt (
    .clk(clk), .rst(rst), .cont(cont), .clr(cmd_clear),
    .inc(err_inc), .cnt(err_cnt), .over(err_over));

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_ovf    <= 1'b0;
      byte_ovf   <= 1'b0;
      wrap_pulse <= 1'b0;
      err_snap   <= '0;
      pkt_snap   <= '0;
      byte_snap  <= '0;
    end else begin
      wrap_pulse <= cont && (pkt_over || byte_over || err_over);
      if (cmd_clear) begin
        pkt_ovf  <= 1'b0;
        byte_ovf <= 1'b0;
      end else begin
        pkt_ovf  <= pkt_ovf | pkt_over;
        byte_ovf <= byte_ovf | byte_over;
      end
      if (cmd_latch || cmd_clear) begin
        err_snap  <= err_cnt;
        pkt_snap  <= pkt_cnt;
        byte_snap <= byte_cnt;
      end
    end
  end

  assert_loss_needs_lock_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_loss) |-> $past(locked));
  assert_idle_no_count_R4: assert property (@(posedge clk) disable iff (rst)
    (!act && !cmd_clear) |=> $stable(byte_cnt));
  assert_clear_flags_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_clear |=> (!pkt_ovf && !byte_ovf));
  assert_snap_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!cmd_latch && !cmd_clear) |=> $stable(pkt_snap));

endmodule

// File: rtl/bist_pkt_engine.sv
module bist_pkt_engine #(
  parameter int LEN_W    = 8,
  parameter int GAP_W    = 8,
  parameter int PKT_W    = 8,
  parameter int BYTE_W   = 10,
  parameter int ERR_W    = 8,
  parameter int LOCK_RUN = 8,
  parameter int LOSS_RUN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gen_en,
  input  logic              prbs_mode,
  input  logic              send_req,
  input  logic              chk_en,
  input  logic              cont_mode,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [GAP_W-1:0]  gap_len,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic              cmd_latch,
  input  logic              cmd_clear,
  input  logic              stat_ack,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              tx_last,
  output logic              busy,
  output logic              send_pend,
  output logic              pkt_done,
  output logic              locked,
  output logic              sync_loss,
  output logic              pkt_ovf,
  output logic              byte_ovf,
  output logic [ERR_W-1:0]  err_snap,
  output logic [PKT_W-1:0]  pkt_snap,
  output logic [BYTE_W-1:0] byte_snap,
  output logic              wrap_pulse
);

  logic chk_act;

  // In fixed-packet mode the checker follows the generator enable.
  assign chk_act = chk_en && (prbs_mode || gen_en);

  bist_pkt_gen #(.LEN_W(LEN_W), .GAP_W(GAP_W)) u_gen (
    .clk(clk), .rst(rst), .gen_en(gen_en), .prbs_mode(prbs_mode),
    .send_req(send_req), .pkt_len(pkt_len), .gap_len(gap_len),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
    .busy(busy), .send_pend(send_pend), .pkt_done(pkt_done));

  bist_pkt_chk #(.PKT_W(PKT_W), .BYTE_W(BYTE_W), .ERR_W(ERR_W),
                 .LOCK_RUN(LOCK_RUN), .LOSS_RUN(LOSS_RUN)) u_chk (
    .clk(clk), .rst(rst), .act(chk_act), .cont(cont_mode),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
    .cmd_latch(cmd_latch), .cmd_clear(cmd_clear), .stat_ack(stat_ack),
    .locked(locked), .sync_loss(sync_loss), .pkt_ovf(pkt_ovf),
    .byte_ovf(byte_ovf), .err_snap(err_snap), .pkt_snap(pkt_snap),
    .byte_snap(byte_snap), .wrap_pulse(wrap_pulse));

endmodule

// File: tb/bist_pkt_engine_tb_top.sv
module bist_pkt_engine_tb_top;

  localparam int LEN_W = 8, GAP_W = 8, PKT_W = 8, BYTE_W = 10, ERR_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, gen_en, prbs_mode, send_req, chk_en, cont_mode;
  logic [LEN_W-1:0] pkt_len;
  logic [GAP_W-1:0] gap_len;
  logic [7:0] rx_data;
  logic rx_valid, rx_last, cmd_latch, cmd_clear, stat_ack;
  logic [7:0] tx_data;
  logic tx_valid, tx_last, busy, send_pend, pkt_done, locked, sync_loss;
  logic pkt_ovf, byte_ovf, wrap_pulse;
  logic [ERR_W-1:0] err_snap;
  logic [PKT_W-1:0] pkt_snap;
  logic [BYTE_W-1:0] byte_snap;

  logic drv, b_valid, b_last;
  logic [7:0] b_data, mask;
  logic [7:0] inj_val;
  logic inj_alt;
  int inj_req, inj_done;
  int n_checks, n_fail, n_bytes, n_pkts, n_wraps;
  int idle_run;
  logic saw_last, have_prev, finished;
  logic [7:0] prev_b;
  logic [7:0] exp_q[$];

  assign rx_data  = drv ? b_data  : (tx_data ^ mask);
  assign rx_valid = drv ? b_valid : tx_valid;
  assign rx_last  = drv ? b_last  : tx_last;

  bist_pkt_engine dut_i (
    .clk(clk), .rst(rst), .gen_en(gen_en), .prbs_mode(prbs_mode),
    .send_req(send_req), .chk_en(chk_en), .cont_mode(cont_mode),
    .pkt_len(pkt_len), .gap_len(gap_len), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_last(rx_last), .cmd_latch(cmd_latch),
    .cmd_clear(cmd_clear), .stat_ack(stat_ack), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .busy(busy),
    .send_pend(send_pend), .pkt_done(pkt_done), .locked(locked),
    .sync_loss(sync_loss), .pkt_ovf(pkt_ovf), .byte_ovf(byte_ovf),
    .err_snap(err_snap), .pkt_snap(pkt_snap), .byte_snap(byte_snap),
    .wrap_pulse(wrap_pulse));

  // Reference from the recurrence x[n] = x[n-7] ^ x[n-6].
  function automatic logic [7:0] ref_next(input logic [7:0] prev);
    logic x[15];
    logic [7:0] r;
    for (int k = 0; k < 7; k++) x[k] = prev[6-k];
    for (int n = 7; n < 15; n++) x[n] = x[n-7] ^ x[n-6];
    for (int k = 0; k < 8; k++) r[7-k] = x[7+k];
    return r;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops expected fixed bytes, checks PRBS order and gaps.
  always @(negedge clk) begin
    if (rst) begin
      mask <= 8'h00; saw_last <= 1'b0; have_prev <= 1'b0; idle_run <= 0;
      n_bytes <= 0; n_pkts <= 0; n_wraps <= 0; inj_done <= 0;
    end else begin
      if (wrap_pulse) n_wraps <= n_wraps + 1;
      if (tx_valid) begin
        check("R2 busy during byte", busy, 1);
        if (!prbs_mode) begin
          if (exp_q.size() == 0) check("R2 unexpected byte", 1, 0);
          else begin
            check("R2 fixed byte", tx_data, exp_q.pop_front());
            check("R2 last marker", tx_last, exp_q.size() == 0);
          end
        end else begin
          if (have_prev) check("R3 prbs order", tx_data, ref_next(prev_b));
          prev_b <= tx_data; have_prev <= 1'b1;
          if (saw_last) check("R3 gap length", idle_run, gap_len);
        end
        saw_last <= tx_last;
        idle_run <= 0;
        n_bytes <= n_bytes + 1;
        if (tx_last) n_pkts <= n_pkts + 1;
        if (inj_done < inj_req && (!inj_alt || !n_bytes[0])) begin
          mask <= inj_val; inj_done <= inj_done + 1;
        end else mask <= 8'h00;
      end else begin
        mask <= 8'h00;
        if (!busy) saw_last <= 1'b0;
        idle_run <= idle_run + 1;
      end
    end
  end

  task automatic latch();
    cmd_latch = 1'b1; @(negedge clk); cmd_latch = 1'b0;
  endtask

  task automatic clear();
    cmd_clear = 1'b1; @(negedge clk); cmd_clear = 1'b0;
  endtask

  task automatic drive_byte(input logic with_clear);
    b_valid = 1'b1; b_last = 1'b1; b_data = 8'hA5; cmd_clear = with_clear;
    @(negedge clk);
    b_valid = 1'b0; b_last = 1'b0; cmd_clear = 1'b0;
  endtask

  task automatic stop_gen();
    gen_en = 1'b0;
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_bytes(input int n);
    int b0;
    b0 = n_bytes;
    gen_en = 1'b1;
    for (int i = 0; i < 20000 && (n_bytes - b0) < n; i++) @(negedge clk);
    stop_gen();
  endtask

  task automatic wait_lock();
    gen_en = 1'b1;
    for (int i = 0; i < 500 && !locked; i++) @(negedge clk);
  endtask

  task automatic wait_inj();
    for (int i = 0; i < 5000 && inj_done < inj_req; i++) @(negedge clk);
  endtask

  initial begin
    finished = 1'b0;
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int base, pbase, w0, snap_keep;
    n_checks = 0; n_fail = 0;
    rst = 1'b1; gen_en = 0; prbs_mode = 0; send_req = 0; chk_en = 0; cont_mode = 0;
    pkt_len = 8'd5; gap_len = 8'd0; cmd_latch = 0; cmd_clear = 0; stat_ack = 0;
    drv = 0; b_valid = 0; b_last = 0; b_data = 0; inj_val = 0; inj_alt = 0; inj_req = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 tx_valid", tx_valid, 0); check("R1 busy", busy, 0);
    check("R1 locked", locked, 0); check("R1 sync_loss", sync_loss, 0);
    check("R1 ovf flags", {pkt_ovf, byte_ovf, wrap_pulse}, 0);
    check("R1 snapshots", err_snap + pkt_snap + byte_snap, 0);
    check("R1 send flags", {send_pend, pkt_done, tx_last}, 0);

    // R2 fixed packet
    chk_en = 1; gen_en = 1; clear();
    for (int i = 0; i < 5; i++) exp_q.push_back(8'(i));
    send_req = 1'b1; @(negedge clk); send_req = 1'b0;
    check("R2 pending", send_pend, 1);
    for (int i = 0; i < 50 && !pkt_done; i++) @(negedge clk);
    check("R2 done", pkt_done, 1);
    check("R2 request self clear", send_pend, 0);
    repeat (3) @(negedge clk);
    check("R2 busy low after", busy, 0);
    check("R2 queue drained", exp_q.size(), 0);
    latch();
    check("R2 packet counted", pkt_snap, 1);
    check("R2 bytes counted", byte_snap, 5);

    // R4 checker gating
    drv = 1; gen_en = 0; clear();
    drive_byte(0); drive_byte(0); latch();
    check("R4 disabled with fixed mode and gen off", byte_snap, 0);
    prbs_mode = 1;
    drive_byte(0); drive_byte(0); latch();
    check("R4 active with prbs mode", byte_snap, 2);
    chk_en = 0;
    drive_byte(0); drive_byte(0); latch();
    check("R4 chk_en low", byte_snap, 2);
    chk_en = 1;

    // R8 clear in the same cycle as a received packet
    clear();
    drive_byte(0); drive_byte(0); drive_byte(0);
    drive_byte(1);
    check("R8 snapshot before clear pkt", pkt_snap, 3);
    check("R8 snapshot before clear byte", byte_snap, 3);
    latch();
    check("R8 same-cycle byte counted after clear", {pkt_snap, byte_snap}, {8'd1, 10'd1});
    drv = 0;

    // R3 R5 R7 PRBS run with injected errors
    pkt_len = 8'd6; gap_len = 8'd3; cont_mode = 0;
    clear(); base = n_bytes; pbase = n_pkts;
    wait_lock();
    check("R5 lock", locked, 1);
    inj_val = 8'h89; inj_alt = 0; inj_req = inj_req + 1;
    run_bytes(30);
    latch();
    check("R5 error bits", err_snap, 3);
    check("R7 byte snapshot", byte_snap, n_bytes - base);
    check("R7 packet snapshot", pkt_snap, n_pkts - pbase);
    snap_keep = byte_snap;
    run_bytes(12);
    check("R7 snapshot holds without command", byte_snap, snap_keep);
    latch();
    check("R7 snapshot follows counting", byte_snap, n_bytes - base);

    // R9 error saturation
    clear(); w0 = n_wraps;
    gen_en = 1;
    inj_val = 8'hFF; inj_alt = 1; inj_req = inj_req + 40;
    wait_inj(); stop_gen(); latch();
    check("R9 error saturates", err_snap, 255);
    check("R10 no wrap in single mode", n_wraps - w0, 0);

    // R10 error wrap
    cont_mode = 1; clear(); w0 = n_wraps;
    gen_en = 1;
    inj_req = inj_req + 40;
    wait_inj(); stop_gen(); latch();
    check("R10 error wraps", err_snap, 320 % 256);
    check("R10 wrap pulse", (n_wraps - w0) > 0, 1);

    // R11 R9 byte overflow, single
    cont_mode = 0; gap_len = 8'd1; inj_alt = 0;
    clear(); base = n_bytes; pbase = n_pkts;
    run_bytes(1100); latch();
    check("R9 byte saturates", byte_snap, 1023);
    check("R11 byte flag", byte_ovf, 1);
    check("R11 packet flag independent", pkt_ovf, 0);
    check("R9 packets below max", pkt_snap, n_pkts - pbase);

    // R10 byte wrap, continuous
    cont_mode = 1; clear();
    check("R8 clear drops flags", {pkt_ovf, byte_ovf}, 0);
    base = n_bytes;
    run_bytes(1100); latch();
    check("R10 byte wraps", byte_snap, (n_bytes - base) % 1024);
    check("R11 byte flag in continuous", byte_ovf, 1);

    // R11 packet overflow
    cont_mode = 0; pkt_len = 8'd1; gap_len = 8'd0;
    clear(); base = n_bytes;
    run_bytes(300); latch();
    check("R11 packet flag", pkt_ovf, 1);
    check("R9 packet saturates", pkt_snap, 255);
    check("R11 byte flag stays clear", byte_ovf, 0);
    check("R11 bytes", byte_snap, n_bytes - base);

    // R6 sync loss
    pkt_len = 8'd6; gap_len = 8'd2;
    wait_lock();
    inj_val = 8'h01; inj_alt = 0; inj_req = inj_req + 4;
    wait_inj(); @(negedge clk); @(negedge clk);
    check("R6 lock dropped", locked, 0);
    check("R6 sync loss set", sync_loss, 1);
    for (int i = 0; i < 500 && !locked; i++) @(negedge clk);
    check("R6 relock", locked, 1);
    check("R6 sync loss sticky", sync_loss, 1);
    stat_ack = 1; @(negedge clk); stat_ack = 0;
    check("R6 ack clears", sync_loss, 0);
    stop_gen();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule